// File: doc/BRIEF.md
# Trace Stimulus Port Write Decoder

This block sits behind the software trace stimulus address region. Each trace channel owns a 256-byte window, and software writes into a chosen word of that window to emit one trace packet. The decoder takes the channel number from the address bits above the window and the packet kind from the word offset inside the window. Two offset bits act as per-packet options: one asks for a timestamp and one asks for guaranteed rather than invariant-timing delivery. The result goes out as one packet request that carries the channel, the kind, both option flags, the payload trimmed to the written size, and the size code.

A write that cannot become a packet is dropped without any response on the write side, and a sticky error flag records it. A write is dropped if it targets a channel at or above the configured port count, a channel whose port-enable bit is clear, an offset that names no packet kind, or a size the block does not support. The output uses a valid/ready handshake and has a single register stage. The write side sees `wr_ready` low only while a held packet is waiting and the consumer is not taking it.

Control is a two-state machine. `ST_EMPTY` means no packet is held. `ST_FULL` means a packet is presented on the output. The transitions are:
- LOAD (`ST_EMPTY`→`ST_FULL`): a valid write is accepted.
- DRAIN (`ST_FULL`→`ST_EMPTY`): the consumer takes the packet and no valid write arrives in that cycle.
- REFILL (`ST_FULL`→`ST_FULL`): the consumer takes the packet and a new valid write is loaded in the same cycle.
- STALL (`ST_FULL`→`ST_FULL`): the consumer is not ready.

Dropped writes never leave `ST_EMPTY` and never trigger LOAD or REFILL.

Top module: `stim_port_decoder`

## Requirements
- R1: The packet channel equals address bits [ADDR_W-1:8]; the low 8 address bits are the in-window offset.
- R2: Offset bits [6:4] select the packet kind: 001 gives data (`pkt_kind` 0), 110 gives flag (`pkt_kind` 1), and 111 gives trigger (`pkt_kind` 2). Offset bits [2:0] must be zero. Any other offset is dropped and sets the error flag.
- R3: Offset bit 7 clear sets `pkt_guar`. Offset bit 3 clear sets `pkt_ts`. Either bit set leaves its flag low.
- R4: Size codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. Code 3 is accepted only when FUND64=1; otherwise the write is dropped and sets the error flag. Payload bytes above the size are zero.
- R5: A flag packet always has size code 0 and carries only the low byte of the written data.
- R6: A write to channel number ≥ `cfg_num_ports` is dropped and sets the error flag.
- R7: A write to channel n is dropped and sets the error flag when `port_en[n mod 32]` is 0.
- R8: `err_sticky` rises in the cycle after a dropped write and stays high until reset.
- R9: While `pkt_valid` is high and `pkt_ready` is low, all packet outputs hold still and `wr_ready` is low.
- R10: After reset, `pkt_valid` is 0, `err_sticky` is 0 and `wr_ready` is 1.
- R11: With `pkt_ready` held high, a valid write every cycle produces a packet every cycle, one cycle after its write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request present |
| wr_ready | output | 1 | Write can be taken this cycle |
| wr_addr | input | ADDR_W | Write address within the stimulus region |
| wr_data | input | DATA_W | Write data (64 bits when FUND64=1, else 32) |
| wr_size | input | 2 | Size code, log2 of byte count |
| port_en | input | 32 | Per-port enable, indexed by channel mod 32 |
| cfg_num_ports | input | ADDR_W-7 | Number of implemented channels |
| pkt_valid | output | 1 | Packet request present |
| pkt_ready | input | 1 | Consumer takes the packet |
| pkt_chan | output | ADDR_W-8 | Channel number |
| pkt_kind | output | 2 | 0 data, 1 flag, 2 trigger |
| pkt_ts | output | 1 | Timestamp requested |
| pkt_guar | output | 1 | Guaranteed delivery requested |
| pkt_data | output | DATA_W | Payload, trimmed to size |
| pkt_size | output | 2 | Payload size code |
| err_sticky | output | 1 | A write has been dropped since reset |

## Verification
The bound checker watches several properties on every cycle:
- Held packets stay still and the write side is stalled while the consumer holds off.
- Flag packets stay one byte and payload bytes above the size code stay zero.
- Only legal kind codes and size codes appear.
- The error flag never falls.

Other behaviour needs the bench's chosen stimulus, because it depends on which address was written. This covers:
- Which offsets decode to which kind.
- How the option bits map to the flags.
- Drops caused by the port count and by port enables, including the mod-32 wrap on a 64-channel build.
- Rejection of 8-byte writes on a 32-bit build.

// File: rtl/stim_pkg.sv
package stim_pkg;
    localparam int WIN_BITS   = 8;
    localparam int LANE_PORTS = 32;

    typedef enum logic [1:0] {
        PK_DATA = 2'd0,
        PK_FLAG = 2'd1,
        PK_TRIG = 2'd2
    } pkt_kind_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } stage_state_e;
endpackage

// File: rtl/stim_offset_decode.sv
module stim_offset_decode
    import stim_pkg::*;
(
    input  logic [WIN_BITS-1:0] offset,
    output logic                known,
    output pkt_kind_e           kind,
    output logic                ts,
    output logic                guar
);
    always_comb begin
        known = 1'b1;
        kind  = PK_DATA;
        unique case (offset[6:4])
            3'b001:  kind = PK_DATA;
            3'b110:  kind = PK_FLAG;
            3'b111:  kind = PK_TRIG;
            default: known = 1'b0;
        endcase
        if (offset[2:0] != 3'b000) begin
            known = 1'b0;
        end
        // option bits are active when cleared
        ts   = ~offset[3];
        guar = ~offset[7];
    end
endmodule

// File: rtl/stim_write_check.sv
module stim_write_check
    import stim_pkg::*;
#(
    parameter int CH_W   = 8,
    parameter int DATA_W = 64,
    parameter int FUND64 = 1
) (
    input  logic [CH_W-1:0]   chan,
    input  logic [CH_W:0]     num_ports,
    input  logic [LANE_PORTS-1:0] port_en,
    input  logic [1:0]        size,
    input  pkt_kind_e         kind,
    input  logic [DATA_W-1:0] data,
    output logic              size_ok,
    output logic              port_ok,
    output logic              range_ok,
    output logic [DATA_W-1:0] pay,
    output logic [1:0]        pay_size
);
    localparam int NB = DATA_W / 8;

    logic [4:0] lane;
    logic [3:0] nbytes;

    generate
        if (FUND64 != 0) begin : g_wide
            assign size_ok = 1'b1;
        end else begin : g_narrow
            assign size_ok = (size != 2'd3);
        end
    endgenerate

    assign lane     = 5'(chan);
    assign port_ok  = port_en[lane];
    assign range_ok = ({1'b0, chan} < num_ports);
    assign pay_size = (kind == PK_FLAG) ? 2'd0 : size;
    assign nbytes   = 4'd1 << pay_size;

    generate
        for (genvar b = 0; b < NB; b++) begin : g_lane
            assign pay[8*b +: 8] = (4'(b) < nbytes) ? data[8*b +: 8] : 8'h00;
        end
    endgenerate
endmodule

// File: rtl/stim_port_decoder.sv
module stim_port_decoder
    import stim_pkg::*;
#(
    parameter int  ADDR_W = 16,
    parameter int  FUND64 = 1,
    localparam int CH_W   = ADDR_W - WIN_BITS,
    localparam int DATA_W = (FUND64 != 0) ? 64 : 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        wr_size,
    input  logic [31:0]       port_en,
    input  logic [CH_W:0]     cfg_num_ports,
    output logic              pkt_valid,
    input  logic              pkt_ready,
    output logic [CH_W-1:0]   pkt_chan,
    output logic [1:0]        pkt_kind,
    output logic              pkt_ts,
    output logic              pkt_guar,
    output logic [DATA_W-1:0] pkt_data,
    output logic [1:0]        pkt_size,
    output logic              err_sticky
);
    stage_state_e state, state_nx;

    logic [CH_W-1:0]   w_chan;
    logic              w_known, w_ts, w_guar;
    pkt_kind_e         w_kind;
    logic              w_size_ok, w_port_ok, w_range_ok;
    logic [DATA_W-1:0] w_pay;
    logic [1:0]        w_pay_size;
    logic              take, good, drop;
    pkt_kind_e         kind_q;

    assign w_chan = wr_addr[ADDR_W-1:WIN_BITS];

    stim_offset_decode u_dec (
        .offset (wr_addr[WIN_BITS-1:0]),
        .known  (w_known),
        .kind   (w_kind),
        .ts     (w_ts),
        .guar   (w_guar)
    );

    stim_write_check #(
        .CH_W   (CH_W),
        .DATA_W (DATA_W),
        .FUND64 (FUND64)
    ) u_chk_w (
        .chan      (w_chan),
        .num_ports (cfg_num_ports),
        .port_en   (port_en),
        .size      (wr_size),
        .kind      (w_kind),
        .data      (wr_data),
        .size_ok   (w_size_ok),
        .port_ok   (w_port_ok),
        .range_ok  (w_range_ok),
        .pay       (w_pay),
        .pay_size  (w_pay_size)
    );

    assign wr_ready  = (state == ST_EMPTY) || pkt_ready;
    assign take      = wr_valid && wr_ready;
    assign good      = take && w_known && w_size_ok && w_port_ok && w_range_ok;
    assign drop      = take && !good;
    assign pkt_valid = (state == ST_FULL);
    assign pkt_kind  = kind_q;

    // next state: LOAD, DRAIN, REFILL, STALL
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_EMPTY: if (good) state_nx = ST_FULL;
            ST_FULL:  if (pkt_ready && !good) state_nx = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_chan   <= '0;
            kind_q     <= PK_DATA;
            pkt_ts     <= 1'b0;
            pkt_guar   <= 1'b0;
            pkt_data   <= '0;
            pkt_size   <= 2'd0;
            err_sticky <= 1'b0;
        end else begin
            if (good) begin
                pkt_chan <= w_chan;
                kind_q   <= w_kind;
                pkt_ts   <= w_ts;
                pkt_guar <= w_guar;
                pkt_data <= w_pay;
                pkt_size <= w_pay_size;
            end
            if (drop) err_sticky <= 1'b1;
        end
    end
endmodule

// File: rtl/stim_port_decoder_chk.sv
module stim_port_decoder_chk #(
    parameter int CH_W   = 8,
    parameter int DATA_W = 64,
    parameter int FUND64 = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_ready,
    input logic              pkt_valid,
    input logic              pkt_ready,
    input logic [CH_W-1:0]   pkt_chan,
    input logic [1:0]        pkt_kind,
    input logic              pkt_ts,
    input logic              pkt_guar,
    input logic [DATA_W-1:0] pkt_data,
    input logic [1:0]        pkt_size,
    input logic              err_sticky
);
    p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid && !pkt_ready |=> pkt_valid && $stable(pkt_chan) && $stable(pkt_kind)
            && $stable(pkt_ts) && $stable(pkt_guar) && $stable(pkt_data) && $stable(pkt_size));

    p_stall_input_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid && !pkt_ready |-> !wr_ready);

    p_flag_one_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid && pkt_kind == 2'd1 |-> pkt_size == 2'd0 && (pkt_data >> 8) == '0);

    p_payload_trim_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> (pkt_data >> (8 << pkt_size)) == '0);

    p_size_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> (FUND64 != 0) || pkt_size != 2'd3);

    p_kind_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> pkt_kind != 2'd3);

    p_err_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky |=> err_sticky);

    p_reset_state_r10: assert property (@(posedge clk)
        !rst_n |=> !pkt_valid && !err_sticky);
endmodule

bind stim_port_decoder stim_port_decoder_chk #(
    .CH_W   (CH_W),
    .DATA_W (DATA_W),
    .FUND64 (FUND64)
) u_assert (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_ready   (wr_ready),
    .pkt_valid  (pkt_valid),
    .pkt_ready  (pkt_ready),
    .pkt_chan   (pkt_chan),
    .pkt_kind   (pkt_kind),
    .pkt_ts     (pkt_ts),
    .pkt_guar   (pkt_guar),
    .pkt_data   (pkt_data),
    .pkt_size   (pkt_size),
    .err_sticky (err_sticky)
);

// File: tb/stim_port_decoder_tb.sv
`timescale 1ns/1ps
module stim_port_decoder_tb;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n;
    logic        wr_valid, wv_b;
    logic        wr_ready, wr_ready_b;
    logic [11:0] wr_addr;
    logic [13:0] addr_b;
    logic [63:0] wr_data;
    logic [1:0]  wr_size;
    logic [31:0] port_en;
    logic        pkt_valid, pkt_ready;
    logic [3:0]  pkt_chan;
    logic [1:0]  pkt_kind;
    logic        pkt_ts, pkt_guar, err_sticky;
    logic [63:0] pkt_data;
    logic [1:0]  pkt_size;
    logic        pv_b, ts_b, gu_b, err_b;
    logic [5:0]  ch_b;
    logic [1:0]  kind_b, size_b;
    logic [31:0] data_b;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    stim_port_decoder #(.ADDR_W(12), .FUND64(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_size(wr_size), .port_en(port_en),
        .cfg_num_ports(5'd12), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
        .pkt_chan(pkt_chan), .pkt_kind(pkt_kind), .pkt_ts(pkt_ts), .pkt_guar(pkt_guar),
        .pkt_data(pkt_data), .pkt_size(pkt_size), .err_sticky(err_sticky));

    stim_port_decoder #(.ADDR_W(14), .FUND64(0)) u_dut_n32 (
        .clk(clk), .rst_n(rst_n), .wr_valid(wv_b), .wr_ready(wr_ready_b),
        .wr_addr(addr_b), .wr_data(wr_data[31:0]), .wr_size(wr_size), .port_en(port_en),
        .cfg_num_ports(7'd64), .pkt_valid(pv_b), .pkt_ready(1'b1),
        .pkt_chan(ch_b), .pkt_kind(kind_b), .pkt_ts(ts_b), .pkt_guar(gu_b),
        .pkt_data(data_b), .pkt_size(size_b), .err_sticky(err_b));

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_valid = 1'b0; wv_b = 1'b0; pkt_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // expected decode from the requirement text
    function automatic bit kind_of(input logic [7:0] off, output logic [1:0] k);
        k = 2'd0;
        if (off[2:0] != 3'b000) return 0;
        case (off[6:4])
            3'b001: k = 2'd0;
            3'b110: k = 2'd1;
            3'b111: k = 2'd2;
            default: return 0;
        endcase
        return 1;
    endfunction

    function automatic logic [63:0] trim(input logic [63:0] d, input logic [1:0] s);
        logic [63:0] r = '0;
        for (int b = 0; b < 8; b++) if (b < (1 << s)) r[8*b +: 8] = d[8*b +: 8];
        return r;
    endfunction

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        wr_addr = '0; addr_b = '0; wr_data = '0; wr_size = '0; port_en = '1;
        do_reset();

        // R10: reset state
        chk(!pkt_valid && !err_sticky && wr_ready, "R10 reset",
            {pkt_valid, err_sticky, wr_ready}, 3'b001);

        // R8: sticky error
        wr_valid = 1; wr_addr = {4'd1, 8'h98}; wr_size = 2; wr_data = 64'h55;
        @(negedge clk);
        chk(pkt_valid && !err_sticky, "R8 no error after good write", {pkt_valid, err_sticky}, 2'b10);
        wr_addr = {4'd1, 8'h44};
        @(negedge clk);
        chk(!pkt_valid && err_sticky, "R8 bad offset drops and flags", {pkt_valid, err_sticky}, 2'b01);
        wr_addr = {4'd3, 8'h98};
        @(negedge clk);
        chk(pkt_valid && err_sticky, "R8 flag stays high", {pkt_valid, err_sticky}, 2'b11);
        wr_valid = 0;
        @(negedge clk);
        do_reset();

        // R9: stall holds the packet and blocks the write side
        pkt_ready = 0;
        wr_valid = 1; wr_addr = {4'd5, 8'hF8}; wr_size = 1; wr_data = 64'hABCD;
        @(negedge clk);
        wr_addr = {4'd6, 8'h98}; wr_size = 2; wr_data = 64'h1122_3344;
        for (int c = 0; c < 3; c++) begin
            chk(pkt_valid && !wr_ready && pkt_chan == 5 && pkt_kind == 2 && pkt_data == 64'hABCD,
                "R9 held while stalled", {pkt_valid, wr_ready, pkt_chan, pkt_kind, pkt_data},
                {1'b1, 1'b0, 4'd5, 2'd2, 64'hABCD});
            @(negedge clk);
        end
        pkt_ready = 1;
        @(negedge clk);
        wr_valid = 0;
        chk(pkt_valid && pkt_chan == 6 && pkt_data == 64'h1122_3344, "R9 queued write follows release",
            {pkt_valid, pkt_chan, pkt_data}, {1'b1, 4'd6, 64'h1122_3344});
        @(negedge clk);
        chk(!pkt_valid, "R9 drains", pkt_valid, 1'b0);

        // R7: mod-32 port gating on the 64-channel build
        port_en = 32'hFFFF_FFFB;
        wv_b = 1; addr_b = {6'd34, 8'h98}; wr_size = 0; wr_data = 64'h7E;
        @(negedge clk);
        chk(!pv_b && err_b, "R7 ch34 gated by bit 2", {pv_b, err_b}, 2'b01);
        port_en = '1;
        @(negedge clk);
        wv_b = 0;
        chk(pv_b && ch_b == 34 && data_b == 32'h7E, "R7 ch34 accepted when enabled",
            {pv_b, ch_b, data_b}, {1'b1, 6'd34, 32'h7E});
        @(negedge clk);

        // Sweep: R1 R2 R3 R4 R5 R6 R7 R11, one write per cycle
        port_en = ~((32'd1 << 2) | (32'd1 << 9));
        for (int ch = 0; ch < 16; ch++) begin
            for (int o = 0; o < 256; o += 8) begin
                for (int s = 0; s < 4; s++) begin
                    logic [1:0] k, es;
                    logic [7:0] off;
                    logic [63:0] d, ep;
                    bit kn, okA, okB;
                    int idx;
                    idx = (ch * 256 + o) * 4 + s;
                    off = 8'(o);
                    d = {32'(idx) * 32'h9E37_79B1, 32'(idx) * 32'h85EB_CA6B ^ 32'h0123_4567};
                    wr_valid = 1; wv_b = 1;
                    wr_addr = {4'(ch), off}; addr_b = {6'(ch), off};
                    wr_size = 2'(s); wr_data = d;
                    kn  = kind_of(off, k);
                    okA = kn && port_en[ch] && (ch < 12);
                    okB = kn && port_en[ch] && (s != 3);
                    es  = (k == 2'd1) ? 2'd0 : 2'(s);
                    ep  = trim(d, es);
                    @(negedge clk);
                    if (okA)
                        chk(pkt_valid && pkt_chan == 4'(ch) && pkt_kind == k && pkt_ts == !off[3]
                            && pkt_guar == !off[7] && pkt_size == es && pkt_data == ep,
                            "R1 R2 R3 R4 R5 R11 accepted packet",
                            {pkt_valid, pkt_chan, pkt_kind, pkt_ts, pkt_guar, pkt_size, pkt_data},
                            {1'b1, 4'(ch), k, !off[3], !off[7], es, ep});
                    else
                        chk(!pkt_valid, "R2 R6 R7 dropped write", pkt_valid, 1'b0);
                    chk(pv_b == okB && (!okB || data_b == ep[31:0]), "R4 32-bit build size rule",
                        {pv_b, data_b}, {okB, okB ? ep[31:0] : data_b});
                end
            end
        end
        wr_valid = 0; wv_b = 0;
        @(negedge clk);
        chk(err_sticky && err_b, "R8 flags after sweep", {err_sticky, err_b}, 2'b11);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule